// File: doc/BRIEF.md
# Transport Stream Sync Inserter

This block sits at the entry of a transport-stream encoding chain. It takes an MPEG-2 transport byte stream, finds where each packet begins, and passes every packet on with its first byte rewritten to a freshly generated sync value. Input bytes arrive either as whole bytes or as single bits shifted in MSB first. A valid strobe qualifies each input. Packet boundaries come from one of two places. The block can search the data for the sync value and confirm it at the expected spacing, or it can take an external frame-start pulse that opens a packet wherever it falls.

The first packet after lock gets the bitwise complement of the sync value, and so does every eighth packet after it. This marks where a scrambling period begins for stages further down the chain. An upstream device can flag a damaged packet, and the block then sets the transport error indicator in that packet's header. The output is a byte stream with a valid flag and a start-of-packet flag, one byte per strobe.

Top module: `ts_sync_inserter`

## Requirements
- R1: After reset, out_valid, out_sop and locked are all 0.
- R2: When ext_mode=0, the block outputs nothing until the sync value has been seen at three consecutive packet starts spaced pkt_len bytes apart. The third of these bytes is the first one output. Each output byte is registered: it appears with out_valid=1 in the cycle right after the clock edge that captured the strobe completing the input byte.
- R3: With use_custom=1, the block searches for custom_sync and generates custom_sync in place of 0x47. A stream that carries only 0x47 then never locks.
- R4: Number the packets after lock from 0. Packet k starts with the complement of the sync value when k mod 8 is 0, and with the plain sync value otherwise. For the standard value these are 0xB8 and 0x47. The count starts again at 0 each time lock is acquired.
- R5: While locked, the first byte of each packet (out_sop=1) is always the generated sync byte, whatever value arrived. All other bytes pass through unchanged, except bit 7 of the second byte as described in R7. A single corrupted sync byte does not drop lock.
- R6: In search mode, lock is lost when the sync value is missing at three consecutive packet starts. The packet start that makes the third miss is not output, and locked is 0 right after it. A new search then begins, and the next lock starts again with an inverted sync byte.
- R7: If err_in=1 on the strobe that completes a packet's first byte, bit 7 of that packet's second output byte (the transport error indicator) is forced to 1. Otherwise the byte is unchanged.
- R8: When ext_mode=1, a byte whose strobe comes with frame_start=1 opens a new packet whatever its value, even in the middle of a packet. The first such pulse sets locked and produces an inverted sync byte. With no pulse, packets keep repeating every pkt_len bytes.
- R9: With serial_mode=1, the block shifts bits in MSB first on ser_bit. In search mode, byte alignment is taken from the bit position where the sync pattern is first found. After that a byte completes every 8 valid bits.
- R10: The packet length is set by pkt_len, with 188 bytes as the usual transport value (one sync byte and 187 data bytes). One sync byte starts every pkt_len output bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies one input byte (parallel) or one input bit (serial) |
| serial_mode | input | 1 | 1: bit-serial input on ser_bit; 0: byte-parallel input on par_byte |
| par_byte | input | 8 | Parallel input byte |
| ser_bit | input | 1 | Serial input bit, MSB first |
| ext_mode | input | 1 | 1: framing from frame_start; 0: sync search |
| frame_start | input | 1 | External packet-start marker, sampled with in_valid |
| use_custom | input | 1 | 1: use custom_sync instead of 0x47 |
| custom_sync | input | 8 | Programmable sync value |
| pkt_len | input | 8 | Packet length in bytes, including the sync byte |
| err_in | input | 1 | Upstream error flag for the current packet |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is the first byte of a packet |
| out_byte | output | 8 | Output byte |
| locked | output | 1 | Packet framing established |

## Verification
Every output byte is due exactly one register stage after the strobe that completes its input byte. For parallel input that is the byte's own strobe. For serial input it is the strobe of the eighth bit, or of the bit that completes the first sync pattern. Point checks on out_valid, out_sop, out_byte and locked therefore sample 1 ns after the rising edge that captured that strobe. One check also confirms that out_valid has dropped one edge later. Whole-packet results, such as the sync-byte pattern, payload pass-through and the error bit, are checked from a log built at falling edges, which are half a cycle away from any output change. The checks compare this log with packets the bench builds from R2 to R10.

// File: rtl/ts_sync_inserter.sv
module ts_sync_inserter #(
  parameter int          LW          = 8,
  parameter logic [7:0]  STD_SYNC    = 8'h47,
  parameter int          LOCK_HITS   = 3,
  parameter int          LOSE_MISSES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          serial_mode,
  input  logic [7:0]    par_byte,
  input  logic          ser_bit,
  input  logic          ext_mode,
  input  logic          frame_start,
  input  logic          use_custom,
  input  logic [7:0]    custom_sync,
  input  logic [LW-1:0] pkt_len,
  input  logic          err_in,
  output logic          out_valid,
  output logic          out_sop,
  output logic [7:0]    out_byte,
  output logic          locked
);
  localparam int CW = $clog2((LOCK_HITS > LOSE_MISSES ? LOCK_HITS : LOSE_MISSES) + 1);

  logic [7:0]    shreg, sh_next, sync_val, byte_d, out_d;
  logic [2:0]    bcnt, pcnt, cur;
  logic          aligned, fs_pend, byte_v, byte_fs, tracking, err_q;
  logic [CW-1:0] hits, misses;
  logic [LW-1:0] pos;
  logic          pos0, pos_last, match, acquire, lose, emit, start, fresh, drop;

  assign sync_val = use_custom ? custom_sync : STD_SYNC;
  assign sh_next  = {shreg[6:0], ser_bit};
  assign byte_d   = serial_mode ? sh_next : par_byte;
  assign match    = byte_d == sync_val;
  assign pos0     = pos == '0;
  assign pos_last = pos == pkt_len - LW'(1);

  always_comb begin
    if (!serial_mode) begin
      byte_v  = in_valid;
      byte_fs = ext_mode && frame_start;
    end else if (ext_mode) begin
      byte_v  = in_valid && aligned && bcnt == 3'd7 && !frame_start;
      byte_fs = fs_pend;
    end else begin
      byte_v  = in_valid && (aligned ? bcnt == 3'd7 : match);
      byte_fs = 1'b0;
    end
  end

  assign acquire = !ext_mode && tracking && !locked && pos0 && match && hits == CW'(LOCK_HITS - 1);
  assign lose    = !ext_mode && tracking && locked && pos0 && !match && misses == CW'(LOSE_MISSES - 1);
  assign drop    = byte_v && !ext_mode && tracking && pos0 && !match && (!locked || lose);
  assign start   = ext_mode ? (byte_fs || (locked && pos0)) : (tracking && pos0);
  assign emit    = byte_v && (ext_mode ? (byte_fs || locked) : ((locked && !lose) || acquire));
  assign fresh   = ext_mode ? !locked : acquire;
  assign cur     = fresh ? 3'd0 : pcnt;
  assign out_d   = start ? ((cur == 3'd0) ? ~sync_val : sync_val)
                 : (pos == LW'(1)) ? {byte_d[7] | err_q, byte_d[6:0]} : byte_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bcnt    <= '0;
      aligned <= 1'b0;
      fs_pend <= 1'b0;
    end else if (in_valid && serial_mode) begin
      shreg <= sh_next;
      if (ext_mode) begin
        if (frame_start) begin
          aligned <= 1'b1;
          bcnt    <= 3'd1;
          fs_pend <= 1'b1;
        end else if (aligned) begin
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) fs_pend <= 1'b0;
        end
      end else if (aligned) begin
        bcnt <= bcnt + 3'd1;
        if (drop) aligned <= 1'b0;
      end else if (match) begin
        aligned <= 1'b1;
        bcnt    <= 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      tracking <= 1'b0;
      locked   <= 1'b0;
      hits     <= '0;
      misses   <= '0;
      pcnt     <= '0;
      err_q    <= 1'b0;
    end else if (byte_v) begin
      if (ext_mode) begin
        if (start) begin
          pos    <= LW'(1);
          pcnt   <= cur + 3'd1;
          locked <= 1'b1;
          err_q  <= err_in;
        end else if (locked) begin
          pos <= pos_last ? '0 : pos + LW'(1);
        end
      end else if (!tracking) begin
        if (match) begin
          tracking <= 1'b1;
          hits     <= CW'(1);
          misses   <= '0;
          pos      <= LW'(1);
        end
      end else if (pos0) begin
        pos <= LW'(1);
        if (match) begin
          misses <= '0;
          if (!locked && hits != CW'(LOCK_HITS - 1)) hits <= hits + CW'(1);
        end else if (!locked) begin
          tracking <= 1'b0;
          hits     <= '0;
        end else if (lose) begin
          tracking <= 1'b0;
          locked   <= 1'b0;
          misses   <= '0;
          hits     <= '0;
        end else begin
          misses <= misses + CW'(1);
        end
        if (acquire) locked <= 1'b1;
        if (emit) begin
          pcnt  <= cur + 3'd1;
          err_q <= err_in;
        end
      end else begin
        pos <= pos_last ? '0 : pos + LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= emit;
      out_sop   <= emit && start;
      out_byte  <= out_d;
    end
  end

  assert_sop_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  assert_sop_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_byte == $past(sync_val) || out_byte == ~$past(sync_val)));
  assert_first_inverted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (out_sop && out_byte == ~$past(sync_val)));
  assert_out_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);
  assert_out_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/ts_sync_inserter_tb_top.sv
module ts_sync_inserter_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, serial_mode = 0, ser_bit = 0, ext_mode = 0, frame_start = 0;
  logic use_custom = 0, err_in = 0;
  logic [7:0] par_byte = 0, custom_sync = 8'h5A, pkt_len = 8'd10;
  logic out_valid, out_sop, locked;
  logic [7:0] out_byte;
  int checks = 0, fails = 0, ncap = 0;
  logic [7:0] cap_b [2048];
  logic       cap_s [2048];

  always #5 clk = ~clk;

  ts_sync_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .serial_mode(serial_mode),
    .par_byte(par_byte), .ser_bit(ser_bit), .ext_mode(ext_mode),
    .frame_start(frame_start), .use_custom(use_custom), .custom_sync(custom_sync),
    .pkt_len(pkt_len), .err_in(err_in), .out_valid(out_valid), .out_sop(out_sop),
    .out_byte(out_byte), .locked(locked));

  always @(negedge clk)
    if (rst_n && out_valid && ncap < 2048) begin
      cap_b[ncap] = out_byte;
      cap_s[ncap] = out_sop;
      ncap++;
    end

  function automatic logic [7:0] pay(input int j);
    return 8'(j & 63);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reset_dut(input logic ser, input logic ext, input logic cus, input int len);
    serial_mode = ser; ext_mode = ext; use_custom = cus; pkt_len = 8'(len);
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    ncap = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, input logic fs, input logic er);
    @(negedge clk);
    par_byte = b; frame_start = fs; err_in = er; in_valid = 1;
    @(posedge clk);
    #1 in_valid = 0; frame_start = 0; err_in = 0;
  endtask

  task automatic put_bit(input logic bt, input logic er);
    @(negedge clk);
    ser_bit = bt; err_in = er; in_valid = 1;
    @(posedge clk);
    #1 in_valid = 0; err_in = 0;
  endtask

  task automatic put_pkt(input logic [7:0] s, input logic er);
    for (int j = 0; j < int'(pkt_len); j++) begin
      logic [7:0] b;
      b = (j == 0) ? s : pay(j);
      if (serial_mode)
        for (int i = 7; i >= 0; i--) put_bit(b[i], er && j == 0 && i == 0);
      else
        put_byte(b, 1'b0, er && j == 0);
    end
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_pkt(input int base, input logic [7:0] s, input logic [7:0] b1, input string req);
    int bad;
    bad = 0;
    chk(cap_s[base] == 1'b1 && cap_b[base] == s, req, cap_b[base], s);
    chk(cap_b[base+1] == b1 && !cap_s[base+1], req, cap_b[base+1], b1);
    for (int j = 2; j < int'(pkt_len); j++)
      if (cap_b[base+j] != pay(j) || cap_s[base+j]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    reset_dut(0, 0, 0, 10);
    chk(!out_valid && !out_sop && !locked, "R1", {out_valid, out_sop, locked}, 0);
  endtask

  task automatic t_search_lock;
    reset_dut(0, 0, 0, 10);
    put_byte(8'h11, 0, 0);
    put_byte(8'h22, 0, 0);
    put_pkt(8'h47, 0);
    put_pkt(8'h47, 0);
    chk(!locked && ncap == 0, "R2 no lock after two syncs", ncap, 0);
    for (int k = 0; k < 10; k++) put_pkt(8'h47, 0);
    settle();
    chk(locked, "R2 locked", locked, 1);
    chk(ncap == 100, "R2 output count", ncap, 100);
    for (int k = 0; k < 10; k++)
      chk_pkt(k * 10, (k % 8 == 0) ? 8'hB8 : 8'h47, 8'h01, "R4 R5 packet");
  endtask

  task automatic t_custom;
    reset_dut(0, 0, 1, 10);
    for (int k = 0; k < 3; k++) put_pkt(8'h47, 0);
    chk(!locked && ncap == 0, "R3 standard value ignored", ncap, 0);
    for (int k = 0; k < 4; k++) put_pkt(8'h5A, 0);
    settle();
    chk(ncap == 20, "R3 output count", ncap, 20);
    chk_pkt(0, 8'hA5, 8'h01, "R3 inverted custom");
    chk_pkt(10, 8'h5A, 8'h01, "R3 custom");
  endtask

  task automatic t_regen_loss;
    reset_dut(0, 0, 0, 10);
    for (int k = 0; k < 3; k++) put_pkt(8'h47, 0);
    put_pkt(8'h00, 0);
    put_pkt(8'h47, 0);
    put_pkt(8'h13, 0);
    put_pkt(8'hFF, 0);
    put_byte(8'h00, 0, 0);
    chk(!locked, "R6 lock lost after third miss", locked, 0);
    for (int j = 1; j < 10; j++) put_byte(pay(j), 0, 0);
    for (int k = 0; k < 3; k++) put_pkt(8'h47, 0);
    settle();
    chk(ncap == 60, "R6 output count", ncap, 60);
    chk_pkt(0, 8'hB8, 8'h01, "R4 first after lock");
    chk_pkt(10, 8'h47, 8'h01, "R5 corrupted sync regenerated");
    chk_pkt(20, 8'h47, 8'h01, "R5 lock held");
    chk_pkt(30, 8'h47, 8'h01, "R5 miss one");
    chk_pkt(40, 8'h47, 8'h01, "R5 miss two");
    chk_pkt(50, 8'hB8, 8'h01, "R6 relock inverted");
  endtask

  task automatic t_error;
    reset_dut(0, 0, 0, 10);
    for (int k = 0; k < 3; k++) put_pkt(8'h47, 0);
    put_byte(8'h47, 0, 1);
    chk(out_valid && out_sop && out_byte == 8'h47, "R2 one-cycle latency", out_byte, 8'h47);
    @(posedge clk);
    #1 chk(!out_valid, "R2 single cycle valid", out_valid, 0);
    for (int j = 1; j < 10; j++) put_byte(pay(j), 0, 0);
    put_pkt(8'h47, 0);
    settle();
    chk(ncap == 30, "R7 output count", ncap, 30);
    chk_pkt(0, 8'hB8, 8'h01, "R7 clean packet");
    chk_pkt(10, 8'h47, 8'h81, "R7 error flag");
    chk_pkt(20, 8'h47, 8'h01, "R7 flag cleared");
  endtask

  task automatic t_ext;
    int nsop;
    reset_dut(0, 1, 0, 10);
    for (int k = 0; k < 3; k++) put_byte(8'h47, 0, 0);
    chk(!locked && ncap == 0, "R8 no output before pulse", ncap, 0);
    put_byte(8'h00, 1, 0);
    for (int j = 1; j < 10; j++) put_byte(pay(j), 0, 0);
    put_byte(8'h33, 0, 0);
    for (int j = 1; j < 10; j++) put_byte(pay(j), 0, 0);
    put_byte(8'h55, 0, 0);
    for (int j = 1; j < 4; j++) put_byte(pay(j), 0, 0);
    put_byte(8'h66, 1, 0);
    for (int j = 1; j < 10; j++) put_byte(pay(j), 0, 0);
    settle();
    chk(ncap == 34, "R8 output count", ncap, 34);
    chk_pkt(0, 8'hB8, 8'h01, "R8 pulse start inverted");
    chk_pkt(10, 8'h47, 8'h01, "R8 free-running wrap");
    chk(cap_s[20] && cap_b[20] == 8'h47, "R8 wrap start", cap_b[20], 8'h47);
    chk_pkt(24, 8'h47, 8'h01, "R8 mid-packet restart");
    nsop = 0;
    for (int i = 0; i < 34; i++) if (cap_s[i]) nsop++;
    chk(nsop == 4, "R8 start count", nsop, 4);
  endtask

  task automatic t_serial;
    reset_dut(1, 0, 0, 10);
    for (int i = 0; i < 3; i++) put_bit(1'b0, 0);
    for (int k = 0; k < 4; k++) put_pkt(8'h47, 0);
    settle();
    chk(ncap == 20, "R9 output count", ncap, 20);
    chk_pkt(0, 8'hB8, 8'h01, "R9 serial first");
    chk_pkt(10, 8'h47, 8'h01, "R9 serial second");
  endtask

  task automatic t_long;
    reset_dut(0, 0, 0, 188);
    for (int k = 0; k < 3; k++) put_pkt(8'h47, 0);
    settle();
    chk(ncap == 188, "R10 output count", ncap, 188);
    chk_pkt(0, 8'hB8, 8'h01, "R10 full-length packet");
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_search_lock();
    t_custom();
    t_regen_loss();
    t_error();
    t_ext();
    t_serial();
    t_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule